// File: doc/BRIEF.md
# NAND Command and Address Front End

This block sits at the device side of a byte-wide NAND flash bus. It watches the shared 8-bit bus together with the chip-enable, write-enable, command-latch and address-latch strobes. A write counts when write enable rises while chip enable is low. Write enable is sampled on the block clock, and a rising edge is detected from two successive samples. A write with only the command latch high is a command. A write with only the address latch high is an address byte. Other writes are dropped.

Commands are decoded into operation requests. Each request appears on `op_valid`/`op_code` for a single clock. A request is raised on the last address byte for a read or copy-back, on the confirm code for a program or erase, and on the command itself for the single-cycle operations. The block assembles a 25-bit byte address and keeps a three-way page pointer. The pointer selects the first half, the second half or the spare area, and its value drives address bit 8. A second-half selection falls back to the first half after one data access. While the device reports busy, only the status and reset commands are taken.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset `op_valid`=0, `op_code`=0, `addr`=0 and `region`=0 (first half).
- R2: A byte is taken only on a sampled rising edge of `we_n` with `ce_n` low. A write with `ce_n` high, or with `cle` and `ale` both high, changes nothing.
- R3: A read setup (00h, 01h or an accepted 50h) followed by three address bytes places the bytes at addr[7:0], addr[16:9] and addr[24:17], in that order. A READ request (`op_code`=1) is raised in the cycle after the third byte is sampled.
- R4: Region encoding is 0 for first half, 1 for second half and 2 for spare. 00h selects 0, 01h selects 1 and 50h selects 2. addr[8] is 1 only in region 1.
- R5: In region 1, one cycle with `data_acc` high returns the region to 0 on the next clock. In regions 0 and 2, `data_acc` has no effect.
- R6: 50h is ignored when `spare_dis` is high. The region is kept and later address bytes start no read.
- R7: 80h, three address bytes, then 10h raises PROGRAM (`op_code`=2) in the cycle after 10h.
- R8: 60h then two address bytes loads addr[16:9] and addr[24:17] and leaves addr[7:0] untouched. A following D0h raises ERASE (`op_code`=4).
- R9: 8Ah, received after a read that was started by 00h has completed, followed by three address bytes, raises COPYBACK (`op_code`=3).
- R10: 90h raises READID (5), 70h raises STATUS (6) and FFh raises RESET (7), each in the cycle after the command. FFh also sets the region to 0 and cancels any pending sequence.
- R11: While `busy` is high, only 70h and FFh are acted on. Other commands and all address bytes are ignored.
- R12: A confirm code (10h, D0h, 8Ah) without its matching setup is ignored. An unknown code cancels a pending sequence, so a later confirm is ignored.
- R13: `op_valid` is high for exactly one clock per request, and `op_code` is 0 whenever `op_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, a byte is taken on its sampled rise |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| io_in | input | 8 | Shared command/address bus |
| spare_dis | input | 1 | High blocks the spare-area pointer command |
| data_acc | input | 1 | One-cycle pulse per data byte access |
| busy | input | 1 | Device busy indication |
| op_valid | output | 1 | One-cycle operation request strobe |
| op_code | output | 3 | Requested operation, 0 when idle |
| addr | output | 25 | Assembled byte address |
| region | output | 2 | Page pointer region |

## Verification
A wrong sequencing state shows up as a missing or extra request. It appears on `op_valid` in the clock after the confirm or final address byte. A mis-tracked byte slot shows up in `addr` one clock after the byte's write-enable rise. A wrong pointer shows up in `region` and addr[8] one clock after the command or the data access. The reference model compares all outputs on every clock, so each such fault is reported within one cycle of its cause.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam int BUS_W   = 8;
    localparam int COL_CYC = 1;
    localparam int ROW_CYC = 2;
    localparam int FULL_CYC = COL_CYC + ROW_CYC;
    localparam int SLOT_W  = $clog2(FULL_CYC);
    localparam int ADDR_W  = FULL_CYC * BUS_W + 1;

    localparam logic [BUS_W-1:0] C_RD_FIRST  = 8'h00;
    localparam logic [BUS_W-1:0] C_RD_SECOND = 8'h01;
    localparam logic [BUS_W-1:0] C_RD_SPARE  = 8'h50;
    localparam logic [BUS_W-1:0] C_PG_SETUP  = 8'h80;
    localparam logic [BUS_W-1:0] C_PG_CONF   = 8'h10;
    localparam logic [BUS_W-1:0] C_CB_SETUP  = 8'h8A;
    localparam logic [BUS_W-1:0] C_ER_SETUP  = 8'h60;
    localparam logic [BUS_W-1:0] C_ER_CONF   = 8'hD0;
    localparam logic [BUS_W-1:0] C_READ_ID   = 8'h90;
    localparam logic [BUS_W-1:0] C_STATUS    = 8'h70;
    localparam logic [BUS_W-1:0] C_RESET     = 8'hFF;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_CMD  = 2'd1,
        EV_ADDR = 2'd2
    } ev_kind_t;

    typedef struct packed {
        ev_kind_t         kind;
        logic [BUS_W-1:0] val;
    } bus_evt_t;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_READ     = 3'd1,
        OP_PROGRAM  = 3'd2,
        OP_COPYBACK = 3'd3,
        OP_ERASE    = 3'd4,
        OP_READID   = 3'd5,
        OP_STATUS   = 3'd6,
        OP_RESET    = 3'd7
    } op_t;

    typedef enum logic [1:0] {
        RG_FIRST  = 2'd0,
        RG_SECOND = 2'd1,
        RG_SPARE  = 2'd2
    } region_t;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_RD_ADDR = 3'd1,
        PH_RD_DONE = 3'd2,
        PH_PG_ADDR = 3'd3,
        PH_PG_WAIT = 3'd4,
        PH_ER_ADDR = 3'd5,
        PH_ER_WAIT = 3'd6,
        PH_CB_ADDR = 3'd7
    } phase_t;

    function automatic logic cmd_allowed(input logic [BUS_W-1:0] code, input logic busy);
        return !busy || (code == C_STATUS) || (code == C_RESET);
    endfunction

endpackage

// File: rtl/nfc_bus_sample.sv
module nfc_bus_sample
    import nfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             cle,
    input  logic             ale,
    input  logic [BUS_W-1:0] io_in,
    output bus_evt_t         evt
);

    logic we_d;
    logic we_rise;

    always_ff @(posedge clk) begin
        if (rst) we_d <= 1'b1;
        else     we_d <= we_n;
    end

    assign we_rise = !we_d && we_n && !ce_n;

    always_comb begin
        evt.val  = io_in;
        evt.kind = EV_NONE;
        if (we_rise && cle && !ale)      evt.kind = EV_CMD;
        else if (we_rise && ale && !cle) evt.kind = EV_ADDR;
    end

endmodule

// File: rtl/nfc_cmd_seq.sv
module nfc_cmd_seq
    import nfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              busy,
    input  logic              spare_dis,
    output logic              op_valid,
    output op_t               op_code,
    output logic              addr_we,
    output logic [SLOT_W-1:0] addr_slot,
    output logic              ptr_we,
    output region_t           ptr_val
);

    localparam logic [SLOT_W-1:0] LAST_FULL = SLOT_W'(FULL_CYC - 1);
    localparam logic [SLOT_W-1:0] LAST_ROW  = SLOT_W'(ROW_CYC - 1);
    localparam logic [SLOT_W-1:0] ROW_BASE  = SLOT_W'(COL_CYC);

    phase_t            phase, phase_n;
    logic [SLOT_W-1:0] cnt, cnt_n;
    logic              rd_first, rd_first_n;
    logic              opv_n;
    op_t               opc_n;

    task automatic start_seq(input phase_t ph);
        phase_n = ph;
        cnt_n   = '0;
    endtask

    always_comb begin
        phase_n    = phase;
        cnt_n      = cnt;
        rd_first_n = rd_first;
        opv_n      = 1'b0;
        opc_n      = OP_NONE;
        addr_we    = 1'b0;
        addr_slot  = '0;
        ptr_we     = 1'b0;
        ptr_val    = RG_FIRST;

        if (evt.kind == EV_CMD && cmd_allowed(evt.val, busy)) begin
            case (evt.val)
                C_RD_FIRST: begin
                    start_seq(PH_RD_ADDR);
                    rd_first_n = 1'b1;
                    ptr_we     = 1'b1;
                    ptr_val    = RG_FIRST;
                end
                C_RD_SECOND: begin
                    start_seq(PH_RD_ADDR);
                    rd_first_n = 1'b0;
                    ptr_we     = 1'b1;
                    ptr_val    = RG_SECOND;
                end
                C_RD_SPARE: begin
                    if (!spare_dis) begin
                        start_seq(PH_RD_ADDR);
                        rd_first_n = 1'b0;
                        ptr_we     = 1'b1;
                        ptr_val    = RG_SPARE;
                    end
                end
                C_PG_SETUP: start_seq(PH_PG_ADDR);
                C_ER_SETUP: start_seq(PH_ER_ADDR);
                C_CB_SETUP: begin
                    if (phase == PH_RD_DONE) start_seq(PH_CB_ADDR);
                end
                C_PG_CONF: begin
                    if (phase == PH_PG_WAIT) begin
                        phase_n = PH_IDLE;
                        opv_n   = 1'b1;
                        opc_n   = OP_PROGRAM;
                    end
                end
                C_ER_CONF: begin
                    if (phase == PH_ER_WAIT) begin
                        phase_n = PH_IDLE;
                        opv_n   = 1'b1;
                        opc_n   = OP_ERASE;
                    end
                end
                C_READ_ID: begin
                    phase_n = PH_IDLE;
                    opv_n   = 1'b1;
                    opc_n   = OP_READID;
                end
                C_STATUS: begin
                    opv_n = 1'b1;
                    opc_n = OP_STATUS;
                end
                C_RESET: begin
                    phase_n = PH_IDLE;
                    opv_n   = 1'b1;
                    opc_n   = OP_RESET;
                    ptr_we  = 1'b1;
                    ptr_val = RG_FIRST;
                end
                default: phase_n = PH_IDLE;
            endcase
        end else if (evt.kind == EV_ADDR && !busy) begin
            case (phase)
                PH_RD_ADDR, PH_PG_ADDR, PH_CB_ADDR: begin
                    addr_we   = 1'b1;
                    addr_slot = cnt;
                    if (cnt == LAST_FULL) begin
                        if (phase == PH_RD_ADDR) begin
                            opv_n   = 1'b1;
                            opc_n   = OP_READ;
                            phase_n = rd_first ? PH_RD_DONE : PH_IDLE;
                        end else if (phase == PH_CB_ADDR) begin
                            opv_n   = 1'b1;
                            opc_n   = OP_COPYBACK;
                            phase_n = PH_IDLE;
                        end else begin
                            phase_n = PH_PG_WAIT;
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                PH_ER_ADDR: begin
                    addr_we   = 1'b1;
                    addr_slot = cnt + ROW_BASE;
                    if (cnt == LAST_ROW) phase_n = PH_ER_WAIT;
                    else                 cnt_n   = cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            rd_first <= 1'b0;
            op_valid <= 1'b0;
            op_code  <= OP_NONE;
        end else begin
            phase    <= phase_n;
            cnt      <= cnt_n;
            rd_first <= rd_first_n;
            op_valid <= opv_n;
            op_code  <= opc_n;
        end
    end

endmodule

// File: rtl/nfc_addr_reg.sv
module nfc_addr_reg
    import nfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] slot,
    input  logic [BUS_W-1:0]  din,
    input  region_t           region,
    output logic [ADDR_W-1:0] addr
);

    logic [BUS_W-1:0] slot_q [FULL_CYC];

    for (genvar g = 0; g < FULL_CYC; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                             slot_q[g] <= '0;
            else if (we && slot == SLOT_W'(g))   slot_q[g] <= din;
        end
    end

    always_comb begin
        addr = '0;
        for (int i = 0; i < COL_CYC; i++)
            addr[i*BUS_W +: BUS_W] = slot_q[i];
        addr[COL_CYC*BUS_W] = (region == RG_SECOND);
        for (int i = COL_CYC; i < FULL_CYC; i++)
            addr[i*BUS_W + 1 +: BUS_W] = slot_q[i];
    end

endmodule

// File: rtl/nfc_ptr.sv
module nfc_ptr
    import nfc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    set_we,
    input  region_t set_val,
    input  logic    data_acc,
    output region_t region
);

    always_ff @(posedge clk) begin
        if (rst)                                   region <= RG_FIRST;
        else if (set_we)                           region <= set_val;
        else if (data_acc && region == RG_SECOND)  region <= RG_FIRST;
    end

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              cle,
    input  logic              ale,
    input  logic [BUS_W-1:0]  io_in,
    input  logic              spare_dis,
    input  logic              data_acc,
    input  logic              busy,
    output logic              op_valid,
    output logic [2:0]        op_code,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        region
);

    bus_evt_t          evt;
    op_t               op_q;
    logic              a_we;
    logic [SLOT_W-1:0] a_slot;
    logic              p_we;
    region_t           p_val;
    region_t           rg_q;

    nfc_bus_sample u_smp (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n),
        .cle(cle), .ale(ale), .io_in(io_in), .evt(evt)
    );

    nfc_cmd_seq u_seq (
        .clk(clk), .rst(rst), .evt(evt), .busy(busy), .spare_dis(spare_dis),
        .op_valid(op_valid), .op_code(op_q), .addr_we(a_we), .addr_slot(a_slot),
        .ptr_we(p_we), .ptr_val(p_val)
    );

    nfc_ptr u_ptr (
        .clk(clk), .rst(rst), .set_we(p_we), .set_val(p_val),
        .data_acc(data_acc), .region(rg_q)
    );

    nfc_addr_reg u_adr (
        .clk(clk), .rst(rst), .we(a_we), .slot(a_slot), .din(evt.val),
        .region(rg_q), .addr(addr)
    );

    assign op_code = op_q;
    assign region  = rg_q;

endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk
    import nfc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              cle,
    input logic              busy,
    input logic              spare_dis,
    input logic              data_acc,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        region
);

    p_single_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !op_valid);

    p_idle_code_r13: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> op_code == 3'd0);

    p_ce_gate_r2: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> !op_valid);

    p_busy_filter_r11: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!op_valid || op_code == 3'd6 || op_code == 3'd7));

    p_fallback_r5: assert property (@(posedge clk) disable iff (rst)
        (region == 2'd1 && data_acc && !(cle && !ce_n)) |=> region == 2'd0);

    p_spare_block_r6: assert property (@(posedge clk) disable iff (rst)
        (region != 2'd2 && spare_dis) |=> region != 2'd2);

    p_erase_col_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd4) |-> $stable(addr[BUS_W-1:0]));

    p_reset_ptr_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd7) |-> region == 2'd0);

endmodule

bind nand_cmd_front nand_cmd_front_chk u_chk (.*);

// File: tb/sim_nand_cmd_front.sv
module sim_nand_cmd_front;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0;
    logic [7:0]  io_in = 8'h00;
    logic        spare_dis = 1'b0, data_acc = 1'b0, busy = 1'b0;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [24:0] addr;
    logic [1:0]  region;

    int checks = 0;
    int errors = 0;

    nand_cmd_front u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
        .io_in(io_in), .spare_dis(spare_dis), .data_acc(data_acc), .busy(busy),
        .op_valid(op_valid), .op_code(op_code), .addr(addr), .region(region)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, evaluated at each falling edge
    bit        m_we_prev;
    int        m_phase;   // 0 idle,1 read addr,2 read done,3 prog addr,4 prog wait,5 erase addr,6 erase wait,7 copy addr
    int        m_cnt;
    bit        m_from00;
    int        m_reg;
    int        m_op;
    bit        m_v;
    byte       m_b[3];

    always @(negedge clk) begin
        if (rst) begin
            m_we_prev = 1; m_phase = 0; m_cnt = 0; m_from00 = 0; m_reg = 0;
            m_op = 0; m_v = 0; m_b[0] = 0; m_b[1] = 0; m_b[2] = 0;
        end else begin
            bit ev;
            ev = !m_we_prev && we_n && !ce_n;
            m_v = 0; m_op = 0;
            if (m_reg == 1 && data_acc) m_reg = 0;
            if (ev && cle && !ale && (!busy || io_in == 8'h70 || io_in == 8'hFF)) begin
                case (io_in)
                    8'h00: begin m_phase = 1; m_cnt = 0; m_from00 = 1; m_reg = 0; end
                    8'h01: begin m_phase = 1; m_cnt = 0; m_from00 = 0; m_reg = 1; end
                    8'h50: if (!spare_dis) begin m_phase = 1; m_cnt = 0; m_from00 = 0; m_reg = 2; end
                    8'h80: begin m_phase = 3; m_cnt = 0; end
                    8'h60: begin m_phase = 5; m_cnt = 0; end
                    8'h8A: if (m_phase == 2) begin m_phase = 7; m_cnt = 0; end
                    8'h10: if (m_phase == 4) begin m_phase = 0; m_v = 1; m_op = 2; end
                    8'hD0: if (m_phase == 6) begin m_phase = 0; m_v = 1; m_op = 4; end
                    8'h90: begin m_phase = 0; m_v = 1; m_op = 5; end
                    8'h70: begin m_v = 1; m_op = 6; end
                    8'hFF: begin m_phase = 0; m_v = 1; m_op = 7; m_reg = 0; end
                    default: m_phase = 0;
                endcase
            end else if (ev && ale && !cle && !busy) begin
                if (m_phase == 1 || m_phase == 3 || m_phase == 7) begin
                    m_b[m_cnt] = io_in;
                    m_cnt++;
                    if (m_cnt == 3) begin
                        if (m_phase == 1) begin m_v = 1; m_op = 1; m_phase = m_from00 ? 2 : 0; end
                        else if (m_phase == 7) begin m_v = 1; m_op = 3; m_phase = 0; end
                        else m_phase = 4;
                    end
                end else if (m_phase == 5) begin
                    m_b[m_cnt + 1] = io_in;
                    m_cnt++;
                    if (m_cnt == 2) m_phase = 6;
                end
            end
            m_we_prev = we_n;
            begin
                logic [24:0] ea;
                ea = {m_b[2], m_b[1], (m_reg == 1), m_b[0]};
                check(op_valid == m_v && op_code == 3'(m_op), "R13 model op", {op_valid, op_code}, {m_v, 3'(m_op)});
                check(addr == ea, "R3 model addr", addr, ea);
                check(region == 2'(m_reg), "R4 model region", region, m_reg);
            end
        end
    end

    task automatic wr(input bit c, input bit a, input logic [7:0] b, input bit ce = 0);
        @(negedge clk); #1;
        ce_n = ce; cle = c; ale = a; io_in = b; we_n = 0;
        @(negedge clk); #1;
        we_n = 1;
        @(negedge clk); #2;
    endtask

    task automatic cmd(input logic [7:0] b);
        wr(1, 0, b);
    endtask

    task automatic adr3(input logic [7:0] b0, b1, b2);
        wr(0, 1, b0); wr(0, 1, b1); wr(0, 1, b2);
    endtask

    task automatic pulse_acc;
        @(negedge clk); #1; data_acc = 1;
        @(negedge clk); #1; data_acc = 0;
        #1;
    endtask

    task automatic expect_op(input string tag, input int code);
        check(op_valid == (code != 0) && op_code == 3'(code), tag, {op_valid, op_code}, {(code != 0), 3'(code)});
    endtask

    bit finished = 0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        #1;
        check(op_valid == 0 && op_code == 0, "R1 reset op", {op_valid, op_code}, 0);
        check(addr == 0, "R1 reset addr", addr, 0);
        check(region == 0, "R1 reset region", region, 0);

        // R3/R4: read from first half
        cmd(8'h00);
        check(region == 0, "R4 first half", region, 0);
        adr3(8'h12, 8'h34, 8'h56);
        expect_op("R3 read strobe", 1);
        check(addr == {8'h56, 8'h34, 1'b0, 8'h12}, "R3 address layout", addr, {8'h56, 8'h34, 1'b0, 8'h12});
        @(negedge clk); #2;
        expect_op("R13 pulse one clock", 0);

        // R9: copy-back after completed 00h read
        cmd(8'h8A);
        expect_op("R9 no strobe on setup", 0);
        adr3(8'hAA, 8'hBB, 8'hCC);
        expect_op("R9 copyback strobe", 3);
        check(addr == {8'hCC, 8'hBB, 1'b0, 8'hAA}, "R9 copyback addr", addr, {8'hCC, 8'hBB, 1'b0, 8'hAA});

        // R4/R5: second half and fallback
        cmd(8'h01);
        check(region == 1, "R4 second half", region, 1);
        adr3(8'h10, 8'h20, 8'h30);
        expect_op("R3 read from second half", 1);
        check(addr[8] == 1, "R4 a8 high", addr[8], 1);
        pulse_acc();
        check(region == 0 && addr[8] == 0, "R5 fallback", {region, addr[8]}, 0);

        // R12: copy-back confirm without a 00h read
        cmd(8'h8A);
        adr3(8'h01, 8'h02, 8'h03);
        expect_op("R12 orphan 8A", 0);

        // R6: spare blocked
        spare_dis = 1;
        cmd(8'h50);
        check(region == 0, "R6 spare blocked", region, 0);
        adr3(8'h04, 8'h05, 8'h06);
        expect_op("R6 no read after blocked 50h", 0);
        spare_dis = 0;
        cmd(8'h50);
        check(region == 2, "R4 spare region", region, 2);
        pulse_acc();
        check(region == 2, "R5 spare ignores access", region, 2);

        // R7: program
        cmd(8'h80);
        adr3(8'h01, 8'h02, 8'h03);
        expect_op("R7 no strobe before confirm", 0);
        cmd(8'h10);
        expect_op("R7 program strobe", 2);
        check(addr == {8'h03, 8'h02, 1'b0, 8'h01}, "R7 program addr", addr, {8'h03, 8'h02, 1'b0, 8'h01});

        // R12: confirm alone
        cmd(8'h10);
        expect_op("R12 orphan 10h", 0);

        // R8: erase
        cmd(8'h60);
        wr(0, 1, 8'h44); wr(0, 1, 8'h55);
        cmd(8'hD0);
        expect_op("R8 erase strobe", 4);
        check(addr == {8'h55, 8'h44, 1'b0, 8'h01}, "R8 erase row only", addr, {8'h55, 8'h44, 1'b0, 8'h01});

        // R12: unknown code cancels program
        cmd(8'h80);
        adr3(8'h61, 8'h62, 8'h63);
        cmd(8'h33);
        expect_op("R12 unknown code", 0);
        cmd(8'h10);
        expect_op("R12 cancelled confirm", 0);

        // R11/R10: busy filtering
        busy = 1;
        cmd(8'h00);
        check(region == 2, "R11 busy ignores 00h", region, 2);
        cmd(8'h90);
        expect_op("R11 busy ignores 90h", 0);
        cmd(8'h70);
        expect_op("R11 status while busy", 6);
        cmd(8'hFF);
        expect_op("R10 reset strobe", 7);
        check(region == 0, "R10 reset region", region, 0);
        busy = 0;

        cmd(8'h90);
        expect_op("R10 read id strobe", 5);

        // R10: reset cancels erase
        cmd(8'h60);
        cmd(8'hFF);
        cmd(8'hD0);
        expect_op("R10 reset cancels pending", 0);

        // R2: ce high, both latches high
        wr(1, 0, 8'h01, 1);
        check(region == 0, "R2 ce high ignored", region, 0);
        wr(1, 1, 8'h01);
        check(region == 0, "R2 both latches ignored", region, 0);

        // R11: address bytes during busy
        cmd(8'h00);
        busy = 1;
        adr3(8'h77, 8'h78, 8'h79);
        busy = 0;
        expect_op("R11 busy address no read", 0);
        check(addr[7:0] == 8'h61, "R11 busy address ignored", addr[7:0], 8'h61);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule